// File: doc/BRIEF.md
# UART Register Front-End with Receive Queue

This block is the processor-facing register slice of a simple UART. It sits on an APB bus and presents a data port, a status word and a control word. Bytes arriving on a byte-stream input are queued in a small receive FIFO and drained by reads of the data port. Bytes written to the data port are forwarded on a byte-stream output. A single interrupt line pulses for one cycle when a byte is received or sent, provided the matching interrupt enable is set.

The serial bit engine, baud generation, parity and framing checks sit elsewhere. This block supplies only the register decode, the direction enables, the receive queue with its occupancy flags, and the interrupt pulse. The receive queue is a linear buffer: slots that have been read are only reclaimed once every stored byte has been read and both pointers return to zero. The transmit side is always reported as empty.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset the control word reads 0, the receive queue is empty, and the status word reads 0x00000006 (bit 1 transmit-shift-empty and bit 2 transmit-queue-empty set, all other bits clear).
- R2: The data port answers at byte offsets 0x00 and 0x03, status at 0x04 and control at 0x08. Offset 0x0C reads zero and ignores writes. Any other offset reads zero, and a write to it changes no register.
- R3: The control word is 32 bits wide, fully writable, and reads back the value last written.
- R4: An input byte handshake (`rx_valid` and `rx_ready` both high at a clock edge) stores the byte only while control bit 0 (receive enable) is set. A stored byte sets status bit 0 (data ready). A byte handshaken while receive is disabled is discarded.
- R5: When a byte is stored and control bit 2 (receive interrupt enable) is set, `irq` is high for exactly the one cycle after that edge.
- R6: A write to the data port while control bit 1 (transmit enable) is set drives `tx_valid` high for the one cycle after the access, with `tx_data` equal to `pwdata[7:0]`. While transmit is disabled no byte is emitted.
- R7: When a byte is emitted and control bit 3 (transmit interrupt enable) is set, `irq` is high for the one cycle after the access.
- R8: A read of the data port returns the oldest unread byte in bits 7:0 (upper bits zero) and consumes it. Status bit 0 clears once no unread byte remains. A read of an empty queue returns zero and leaves the queue unchanged.
- R9: The queue holds up to DEPTH bytes between drains. Reading some bytes does not reclaim their slots. `rx_ready` stays low until the last stored byte has been read, after which DEPTH bytes can be accepted again.
- R10: Status bit 8 is set while the unread count is at least DEPTH/2. Status bit 10 is set while the queue has no free slot (`rx_ready` low). Bits 1 and 2 are always set, and every other status bit reads zero.
- R11: Writes to the status offset are ignored: the status word and the queue contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 5 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| rx_valid | input | 1 | Input byte present |
| rx_data | input | 8 | Input byte |
| rx_ready | output | 1 | Queue has a free slot, or receive is disabled and the byte is dropped |
| tx_valid | output | 1 | Output byte strobe, one cycle |
| tx_data | output | 8 | Output byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench runs a small four-entry instance through every fill level from one byte to full and drains each fill through both data offsets in turn. A design that reclaimed slots early, or never reset its pointers, would show the wrong `rx_ready` or full flag after a partial drain. It also reads an empty queue, which a careless pop would turn into a pointer underflow and stale data. Each enable and interrupt bit is toggled on its own, so that swapped or ignored enables show up as stray or missing strobes and pulses. Status writes and accesses to unused offsets are checked to leave the registers intact.

// File: rtl/uartreg_pkg.sv
package uartreg_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA_B = 5'h03;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;

    localparam int CTL_RX_EN = 0;
    localparam int CTL_TX_EN = 1;
    localparam int CTL_RX_IE = 2;
    localparam int CTL_TX_IE = 3;

    localparam int ST_DREADY  = 0;
    localparam int ST_TSH_EMP = 1;
    localparam int ST_TQ_EMP  = 2;
    localparam int ST_RQ_HALF = 8;
    localparam int ST_RQ_FULL = 10;

    typedef struct packed {
        logic       tx_valid;
        logic [7:0] tx_data;
        logic       irq;
    } txirq_t;
endpackage

// File: rtl/urf_rxq.sv
module urf_rxq #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [PTR_W-1:0] occ,
    output logic             room
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      wr;
        logic [PTR_W-1:0]      rd;
    } q_t;

    q_t q_q, q_d;
    logic             nonempty;
    logic             drain;
    logic [PTR_W-1:0] wbase;

    assign nonempty = (q_q.rd != q_q.wr);
    assign drain    = pop && nonempty && ((q_q.rd + 1'b1) == q_q.wr);
    assign wbase    = drain ? '0 : q_q.wr;

    always_comb begin
        q_d = q_q;
        if (pop && nonempty) begin
            q_d.rd = q_q.rd + 1'b1;
        end
        if (drain) begin
            q_d.rd = '0;
            q_d.wr = '0;
        end
        if (push) begin
            q_d.mem[wbase[IDX_W-1:0]] = push_data;
            q_d.wr = wbase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head = nonempty ? q_q.mem[q_q.rd[IDX_W-1:0]] : 8'h00;
    assign occ  = q_q.wr - q_q.rd;
    assign room = (q_q.wr != PTR_W'(DEPTH));
endmodule

// File: rtl/urf_txirq.sv
module urf_txirq
    import uartreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send,
    input  logic [7:0] send_data,
    input  logic       rx_evt,
    input  logic       tx_evt,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       irq
);
    txirq_t s_q, s_d;

    always_comb begin
        s_d          = s_q;
        s_d.tx_valid = send;
        if (send) begin
            s_d.tx_data = send_data;
        end
        s_d.irq = rx_evt || tx_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid = s_q.tx_valid;
    assign tx_data  = s_q.tx_data;
    assign irq      = s_q.irq;
endmodule

// File: rtl/apb_uart_regs.sv
module apb_uart_regs
    import uartreg_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int HALF  = DEPTH / 2;

    logic [31:0]      ctrl_q, ctrl_d;
    logic             acc, is_data;
    logic             push, pop, send;
    logic [7:0]       head;
    logic [PTR_W-1:0] rx_occ;
    logic             room;
    logic [31:0]      stat;

    assign acc     = psel && penable;
    assign is_data = (paddr == OFS_DATA) || (paddr == OFS_DATA_B);
    assign push    = rx_valid && room && ctrl_q[CTL_RX_EN];
    assign pop     = acc && !pwrite && is_data;
    assign send    = acc && pwrite && is_data && ctrl_q[CTL_TX_EN];
    assign rx_ready = room;

    always_comb begin
        ctrl_d = ctrl_q;
        if (acc && pwrite && (paddr == OFS_CTRL)) begin
            ctrl_d = pwdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    urf_rxq #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head      (head),
        .occ       (rx_occ),
        .room      (room)
    );

    urf_txirq u_txirq (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send),
        .send_data (pwdata[7:0]),
        .rx_evt    (push && ctrl_q[CTL_RX_IE]),
        .tx_evt    (send && ctrl_q[CTL_TX_IE]),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    always_comb begin
        stat             = '0;
        stat[ST_DREADY]  = (rx_occ != '0);
        stat[ST_TSH_EMP] = 1'b1;
        stat[ST_TQ_EMP]  = 1'b1;
        stat[ST_RQ_HALF] = (rx_occ >= PTR_W'(HALF));
        stat[ST_RQ_FULL] = !room;
    end

    always_comb begin
        if (is_data) begin
            prdata = {24'h0, head};
        end else if (paddr == OFS_STAT) begin
            prdata = stat;
        end else if (paddr == OFS_CTRL) begin
            prdata = ctrl_q;
        end else begin
            prdata = '0;
        end
    end
endmodule

// File: rtl/urf_chk.sv
module urf_chk #(
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [4:0]       paddr,
    input logic [31:0]      prdata,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic             irq,
    input logic [PTR_W-1:0] rx_occ
);
    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(psel && penable && pwrite && (paddr == 5'h00 || paddr == 5'h03))); // R6
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((rx_valid && rx_ready) || (psel && penable && pwrite))); // R5
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == 5'h00 && rx_occ == '0) |-> prdata == 32'h0); // R8
    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == 5'h00 && rx_occ == '0 && !rx_valid) |=> rx_occ == '0); // R8
    AST_SCALER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == 5'h0C) |-> prdata == 32'h0); // R2
    AST_TX_STATUS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == 5'h04) |-> prdata[2:1] == 2'b11); // R10
endmodule

bind apb_uart_regs urf_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .irq      (irq),
    .rx_occ   (rx_occ)
);

// File: tb/apb_uart_regs_tb.sv
module apb_uart_regs_tb;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;
    logic        acc, txv_s, irq_s;
    logic [7:0]  txd_s;

    always #2 clk = ~clk;

    apb_uart_regs #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
        txv_s = tx_valid; txd_s = tx_data; irq_s = irq;
    endtask

    task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #1;
        acc = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        irq_s = irq;
    endtask

    function automatic logic [31:0] exp_stat(input int n, input int wrp);
        logic [31:0] s;
        s = 32'h6;
        if (n > 0) s[0] = 1'b1;
        if (n >= DEPTH / 2) s[8] = 1'b1;
        if (wrp == DEPTH) s[10] = 1'b1;
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        apb_rd(5'h08, rd); check("R1 ctrl", rd, 32'h0);
        apb_rd(5'h04, rd); check("R1 status", rd, 32'h6);
        apb_rd(5'h00, rd); check("R8 empty read", rd, 32'h0);
        apb_rd(5'h04, rd); check("R8 empty read keeps status", rd, 32'h6);

        // R3 control read-back
        apb_wr(5'h08, 32'hFFFF_FFFF); apb_rd(5'h08, rd); check("R3 ones", rd, 32'hFFFF_FFFF);
        apb_wr(5'h08, 32'hA5A5_5A5A); apb_rd(5'h08, rd); check("R3 pattern", rd, 32'hA5A5_5A5A);

        // R2 scaler and unused offsets
        apb_wr(5'h0C, 32'h1234_5678); apb_rd(5'h0C, rd); check("R2 scaler", rd, 32'h0);
        for (int a = 16; a < 32; a += 4) begin
            apb_wr(5'(a), 32'hDEAD_BEEF);
            apb_rd(5'(a), rd); check("R2 unused read", rd, 32'h0);
        end
        apb_rd(5'h08, rd); check("R2 ctrl kept", rd, 32'hA5A5_5A5A);

        // R4 receive disabled drops the byte
        apb_wr(5'h08, 32'h4);
        rx_put(8'h77);
        check("R4 disabled accepted", 32'(acc), 32'h1);
        check("R5 no irq when disabled", 32'(irq_s), 32'h0);
        apb_rd(5'h04, rd); check("R4 dropped", rd, 32'h6);

        // R5 interrupt with and without enable
        apb_wr(5'h08, 32'h5);
        rx_put(8'h11); check("R5 rx irq", 32'(irq_s), 32'h1);
        @(negedge clk); #1; check("R5 single pulse", 32'(irq), 32'h0);
        apb_wr(5'h08, 32'h1);
        rx_put(8'h22); check("R5 no irq", 32'(irq_s), 32'h0);
        apb_rd(5'h04, rd); check("R4 data ready", rd, exp_stat(2, 2));
        apb_rd(5'h00, rd); check("R8 first", rd, 32'h11);
        apb_rd(5'h03, rd); check("R8 second alt offset", rd, 32'h22);
        apb_rd(5'h04, rd); check("R8 ready clear", rd, 32'h6);

        // R10 R8 sweep over every fill level
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) begin
                rx_put(8'(8'h30 + n * 7 + k));
                check("R9 accepted", 32'(acc), 32'h1);
                apb_rd(5'h04, rd); check("R10 status fill", rd, exp_stat(k + 1, k + 1));
            end
            #1 check("R10 ready vs fill", 32'(rx_ready), 32'(n != DEPTH));
            for (int k = 0; k < n; k++) begin
                apb_rd((k % 2 == 0) ? 5'h00 : 5'h03, rd);
                check("R8 order", rd, 32'(8'(8'h30 + n * 7 + k)));
                apb_rd(5'h04, rd); check("R9 status drain", rd, exp_stat(n - k - 1, (k == n - 1) ? 0 : n));
            end
        end

        // R9 partial drain does not reclaim
        for (int k = 0; k < DEPTH; k++) rx_put(8'(8'hC0 + k));
        rx_put(8'hEE); check("R9 full refuses", 32'(acc), 32'h0);
        apb_rd(5'h00, rd); apb_rd(5'h00, rd);
        #1 check("R9 no reclaim", 32'(rx_ready), 32'h0);
        apb_rd(5'h04, rd); check("R10 full after partial", rd, exp_stat(DEPTH - 2, DEPTH));

        // R11 status write ignored
        apb_wr(5'h04, 32'hFFFF_FFFF);
        apb_rd(5'h04, rd); check("R11 status kept", rd, exp_stat(DEPTH - 2, DEPTH));
        for (int k = 2; k < DEPTH; k++) begin
            apb_rd(5'h00, rd); check("R11 contents kept", rd, 32'(8'(8'hC0 + k)));
        end
        #1 check("R9 reclaim after drain", 32'(rx_ready), 32'h1);
        for (int k = 0; k < DEPTH; k++) begin
            rx_put(8'(k)); check("R9 refill", 32'(acc), 32'h1);
        end
        for (int k = 0; k < DEPTH; k++) apb_rd(5'h00, rd);

        // R6 R7 transmit
        apb_wr(5'h08, 32'h2);
        apb_wr(5'h00, 32'h0000_01AB);
        check("R6 tx strobe", 32'(txv_s), 32'h1);
        check("R6 tx byte", 32'(txd_s), 32'hAB);
        check("R7 no irq", 32'(irq_s), 32'h0);
        apb_wr(5'h08, 32'hA);
        apb_wr(5'h03, 32'h0000_005C);
        check("R6 alt offset strobe", 32'(txv_s), 32'h1);
        check("R6 alt offset byte", 32'(txd_s), 32'h5C);
        check("R7 tx irq", 32'(irq_s), 32'h1);
        apb_wr(5'h08, 32'h8);
        apb_wr(5'h00, 32'h0000_0033);
        check("R6 disabled no strobe", 32'(txv_s), 32'h0);
        check("R7 disabled no irq", 32'(irq_s), 32'h0);
        apb_wr(5'h08, 32'hB);
        apb_wr(5'h04, 32'h0000_0044);
        check("R6 status write no strobe", 32'(txv_s), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule